// File: doc/BRIEF.md
# MAC Accumulator Saturation and Status Flag Unit

This block post-processes one accumulator of a multiply-accumulate engine that keeps four 48-bit accumulators. Each accumulator is held sign- or zero-extended in a 64-bit raw word. A caller presents the raw word, the accumulator index, the arithmetic mode and the current status word. It then pulses a saturation strobe, a flag strobe, or both.

Saturation clamps or trims the value according to the mode. Signed integer results are clamped to 32 bits, even though overflow is detected at 48 bits. Fractional results are clamped to 48 bits. Unsigned results are clamped to 48 bits, or to zero for very large raw values. Saturation also records overflow in the status word. The flag step ORs the zero, negative, overflow and extension-overflow indications into the status word.

The corrected value and the updated status word are registered. The caller writes them back into its own accumulator storage and status register.

Top module: `mac_acc_guard`

## Requirements
- R1: While reset is asserted and after it is released, `acc_out` and `stat_out` are zero until the first strobe.
- R2: In a cycle where neither `sat_req` nor `flag_req` is high, `acc_out` and `stat_out` keep their previous values.
- R3: The mode is fractional when `mode_fi`=1, signed when `mode_fi`=0 and `mode_su`=1, and unsigned when both are 0. In signed and fractional saturation, a raw value that differs from its own bit 47 sign-extended to 64 bits is an overflow and sets V (status bit 5). A result that is not clamped is that sign-extended value.
- R4: In signed saturation with `omc_en`=1, a saturated result is 0x000000007FFFFFFF when bit 47 is 0, and 0xFFFFFFFF80000000 when bit 47 is 1.
- R5: In unsigned saturation, any 1 in bits 63..48 is an overflow and sets V. With `omc_en`=1, a saturated result is 0 if the raw value is greater than 2^53, and 2^48-1 otherwise. With `omc_en`=0, the result is the raw value masked to 48 bits.
- R6: In fractional saturation with `omc_en`=1, a saturated result is 0x00007FFFFFFFFFFF when bit 47 is 0, and 0xFFFF800000000000 when bit 47 is 1.
- R7: If V is already set in `stat_in` when saturation runs, the value is treated as overflowed: it is clamped when `omc_en`=1 and it sets the PAV bit.
- R8: When V is set after saturation, the sticky overflow bit of the selected accumulator is set. These bits are status bits 3..0, and bit `acc_sel` belongs to accumulator `acc_sel`.
- R9: The flag step sets Z (bit 6) for a zero value. Otherwise it sets N (bit 7) when value bit 47 is 1.
- R10: The flag step sets V (bit 5) when the selected accumulator's sticky overflow bit is set.
- R11: The flag step sets EV (bit 4) in three cases: in fractional mode when bits 63..40 are not all equal; in signed mode when bits 63..32 are not all equal; in unsigned mode when bits 63..32 are not all zero.
- R12: When both strobes are high in the same cycle, the flag step evaluates the saturated value and the status word as updated by saturation.
- R13: No strobe clears a status bit: every bit set in `stat_in` is set in the resulting `stat_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sat_req | input | 1 | One-cycle saturation strobe |
| flag_req | input | 1 | One-cycle flag-update strobe |
| acc_sel | input | 2 | Accumulator index |
| mode_fi | input | 1 | Fractional mode select |
| mode_su | input | 1 | Signed mode select (when not fractional) |
| omc_en | input | 1 | Overflow clamping enable |
| acc_in | input | 64 | Raw accumulator word |
| stat_in | input | 8 | Current status: N,Z,V,EV at 7..4, PAV3..PAV0 at 3..0 |
| acc_out | output | 64 | Corrected accumulator word |
| stat_out | output | 8 | Updated status word |

## Verification
Both results are due one clock edge after the strobe, because each passes through a single output register. The bench drives every input on the falling edge. It then waits for the next rising edge and samples 1 ns later, so each comparison sees exactly the register that the strobe loaded. Hold checks issue a cycle with no strobe and changed inputs, then sample after that cycle's rising edge to confirm that nothing moved.

// File: rtl/mac_guard_pkg.sv
package mac_guard_pkg;

  typedef enum logic [1:0] {
    MODE_UINT = 2'd0,
    MODE_SINT = 2'd1,
    MODE_FRAC = 2'd2
  } acc_mode_e;

  function automatic acc_mode_e decode_mode(input logic fi, input logic su);
    if (fi)      return MODE_FRAC;
    else if (su) return MODE_SINT;
    else         return MODE_UINT;
  endfunction

endpackage

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_guard_pkg::*;
#(
  parameter int RAW_W     = 64,
  parameter int ACC_W     = 48,
  parameter int INT_W     = 32,
  parameter int UCLAMP_SH = 53
) (
  input  logic [RAW_W-1:0] raw,
  input  acc_mode_e        mode,
  input  logic             omc,
  input  logic             v_in,
  output logic [RAW_W-1:0] res,
  output logic             ovf,
  output logic             vflag
);
  localparam int EXT_W = RAW_W - ACC_W;
  localparam logic [RAW_W-1:0] INT_POS  = {{(RAW_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic [RAW_W-1:0] FRAC_POS = {{(EXT_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic [RAW_W-1:0] UMAX     = {{EXT_W{1'b0}}, {ACC_W{1'b1}}};
  localparam logic [RAW_W-1:0] ULIM     = {{(RAW_W-1){1'b0}}, 1'b1} << UCLAMP_SH;

  logic [RAW_W-1:0] sext;
  logic             hi_nz;

  assign sext  = {{EXT_W{raw[ACC_W-1]}}, raw[ACC_W-1:0]};
  assign hi_nz = |raw[RAW_W-1:ACC_W];

  always_comb begin
    res = raw;
    ovf = 1'b0;
    unique case (mode)
      MODE_FRAC: begin
        ovf = (sext != raw);
        res = sext;
        if ((ovf || v_in) && omc) res = sext[RAW_W-1] ? ~FRAC_POS : FRAC_POS;
      end
      MODE_SINT: begin
        ovf = (sext != raw);
        res = sext;
        if ((ovf || v_in) && omc) res = sext[RAW_W-1] ? ~INT_POS : INT_POS;
      end
      default: begin
        ovf = hi_nz;
        if ((ovf || v_in) && omc) res = (raw > ULIM) ? '0 : UMAX;
        else                      res = raw & UMAX;
      end
    endcase
    vflag = ovf | v_in;
  end

endmodule

// File: rtl/mac_flag_unit.sv
module mac_flag_unit
  import mac_guard_pkg::*;
#(
  parameter int RAW_W        = 64,
  parameter int ACC_W        = 48,
  parameter int INT_W        = 32,
  parameter int FRAC_EXT_LSB = 40
) (
  input  logic [RAW_W-1:0] val,
  input  acc_mode_e        mode,
  input  logic             pav_sel,
  output logic             flg_n,
  output logic             flg_z,
  output logic             flg_v,
  output logic             flg_ev
);
  logic [RAW_W-1-FRAC_EXT_LSB:0] frac_top;
  logic [RAW_W-1-INT_W:0]        int_top;
  logic                          frac_same, int_same;

  assign frac_top  = val[RAW_W-1:FRAC_EXT_LSB];
  assign int_top   = val[RAW_W-1:INT_W];
  assign frac_same = (&frac_top) | ~(|frac_top);
  assign int_same  = (&int_top) | ~(|int_top);

  always_comb begin
    flg_z = (val == '0);
    flg_n = !flg_z && val[ACC_W-1];
    flg_v = pav_sel;
    unique case (mode)
      MODE_FRAC: flg_ev = !frac_same;
      MODE_SINT: flg_ev = !int_same;
      default:   flg_ev = |int_top;
    endcase
  end

endmodule

// File: rtl/mac_acc_guard.sv
module mac_acc_guard
  import mac_guard_pkg::*;
#(
  parameter int NUM_ACC      = 4,
  parameter int RAW_W        = 64,
  parameter int ACC_W        = 48,
  parameter int INT_W        = 32,
  parameter int FRAC_EXT_LSB = 40,
  parameter int UCLAMP_SH    = 53,
  localparam int IDX_W       = $clog2(NUM_ACC),
  localparam int STAT_W      = NUM_ACC + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sat_req,
  input  logic              flag_req,
  input  logic [IDX_W-1:0]  acc_sel,
  input  logic              mode_fi,
  input  logic              mode_su,
  input  logic              omc_en,
  input  logic [RAW_W-1:0]  acc_in,
  input  logic [STAT_W-1:0] stat_in,
  output logic [RAW_W-1:0]  acc_out,
  output logic [STAT_W-1:0] stat_out
);
  localparam int EV_BIT = NUM_ACC;
  localparam int V_BIT  = NUM_ACC + 1;
  localparam int Z_BIT  = NUM_ACC + 2;
  localparam int N_BIT  = NUM_ACC + 3;

  logic              rst_q1, rst_sync_n;
  acc_mode_e         mode;
  logic [RAW_W-1:0]  sat_val, flag_val, acc_d;
  logic              sat_ovf, sat_vflag;
  logic [STAT_W-1:0] stat_mid, stat_d;
  logic              f_n, f_z, f_v, f_ev;
  logic              load_en;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  assign mode = decode_mode(mode_fi, mode_su);

  mac_sat_unit #(
    .RAW_W(RAW_W), .ACC_W(ACC_W), .INT_W(INT_W), .UCLAMP_SH(UCLAMP_SH)
  ) u_sat (
    .raw(acc_in), .mode(mode), .omc(omc_en), .v_in(stat_in[V_BIT]),
    .res(sat_val), .ovf(sat_ovf), .vflag(sat_vflag)
  );

  always_comb begin
    stat_mid = stat_in;
    if (sat_req) begin
      stat_mid[V_BIT] = stat_in[V_BIT] | sat_ovf;
      if (sat_vflag) stat_mid[acc_sel] = 1'b1;
    end
  end

  assign flag_val = sat_req ? sat_val : acc_in;

  mac_flag_unit #(
    .RAW_W(RAW_W), .ACC_W(ACC_W), .INT_W(INT_W), .FRAC_EXT_LSB(FRAC_EXT_LSB)
  ) u_flag (
    .val(flag_val), .mode(mode), .pav_sel(stat_mid[acc_sel]),
    .flg_n(f_n), .flg_z(f_z), .flg_v(f_v), .flg_ev(f_ev)
  );

  always_comb begin
    stat_d = stat_mid;
    if (flag_req) begin
      stat_d[N_BIT]  = stat_mid[N_BIT]  | f_n;
      stat_d[Z_BIT]  = stat_mid[Z_BIT]  | f_z;
      stat_d[V_BIT]  = stat_mid[V_BIT]  | f_v;
      stat_d[EV_BIT] = stat_mid[EV_BIT] | f_ev;
    end
    acc_d   = flag_val;
    load_en = sat_req | flag_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_out  <= '0;
      stat_out <= '0;
    end else if (load_en) begin
      acc_out  <= acc_d;
      stat_out <= stat_d;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sat_req && !flag_req) |=> ($stable(acc_out) && $stable(stat_out)));

  // R13
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sat_req || flag_req) |=> ((stat_out & $past(stat_in)) == $past(stat_in)));

  // R5
  uns_width_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sat_req && !mode_fi && !mode_su) |=> (acc_out[RAW_W-1:ACC_W] == '0));

  // R3
  sgn_ext_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sat_req && (mode_fi || mode_su)) |=>
      ((&acc_out[RAW_W-1:ACC_W-1]) || !(|acc_out[RAW_W-1:ACC_W-1])));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_req && !sat_req && acc_in == '0) |=> stat_out[Z_BIT]);

endmodule

// File: tb/tb_mac_acc_guard.sv
`timescale 1ns/1ps
module tb_mac_acc_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sat_req, flag_req, mode_fi, mode_su, omc_en;
  logic [1:0]  acc_sel;
  logic [63:0] acc_in, acc_out;
  logic [7:0]  stat_in, stat_out;
  int checks = 0, fails = 0;
  logic [63:0] last_acc;
  logic [7:0]  last_stat;

  always #2 clk = ~clk;

  mac_acc_guard dut (
    .clk(clk), .rst_n(rst_n), .sat_req(sat_req), .flag_req(flag_req),
    .acc_sel(acc_sel), .mode_fi(mode_fi), .mode_su(mode_su), .omc_en(omc_en),
    .acc_in(acc_in), .stat_in(stat_in), .acc_out(acc_out), .stat_out(stat_out)
  );

  // status: [3:0] sticky per accumulator, 4 EV, 5 V, 6 Z, 7 N
  function automatic logic [71:0] model(input logic s_rq, input logic f_rq,
      input logic [1:0] idx, input logic fi, input logic su, input logic om,
      input logic [63:0] a_in, input logic [7:0] s_in);
    logic [63:0] a;
    logic [7:0]  s;
    longint      sx, top;
    logic        ov, vv;
    a = a_in; s = s_in;
    sx = longint'({{16{a_in[47]}}, a_in[47:0]});
    if (s_rq) begin
      if (fi || su) begin
        ov = (sx != longint'(a_in));
        vv = ov | s[5];
        a = sx;
        if (vv && om) begin
          if (fi) a = (sx < 0) ? 64'hFFFF_8000_0000_0000 : 64'h0000_7FFF_FFFF_FFFF;
          else    a = (sx < 0) ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
        end
      end else begin
        ov = (a_in[63:48] != 16'h0);
        vv = ov | s[5];
        if (vv && om) a = (a_in > (64'd1 << 53)) ? 64'd0 : 64'h0000_FFFF_FFFF_FFFF;
        else          a = a_in & 64'h0000_FFFF_FFFF_FFFF;
      end
      if (ov) s[5] = 1'b1;
      if (vv) s[idx] = 1'b1;
    end
    if (f_rq) begin
      if (a == 64'd0) s[6] = 1'b1;
      else if (a[47]) s[7] = 1'b1;
      if (s[idx]) s[5] = 1'b1;
      if (fi) begin
        top = longint'(a) >>> 40;
        if (top != 0 && top != -1) s[4] = 1'b1;
      end else if (su) begin
        top = longint'(a) >>> 32;
        if (top != 0 && top != -1) s[4] = 1'b1;
      end else if (a[63:32] != 32'h0) s[4] = 1'b1;
    end
    return {a, s};
  endfunction

  task automatic compare(input string req, input logic [63:0] ea, input logic [7:0] es);
    checks++;
    if (acc_out !== ea || stat_out !== es) begin
      fails++;
      $display("FAIL %s acc=%h stat=%b expected acc=%h stat=%b", req, acc_out, stat_out, ea, es);
    end
  endtask

  task automatic run_op(input string req, input logic s_rq, input logic f_rq,
      input logic [1:0] idx, input logic fi, input logic su, input logic om,
      input logic [63:0] a, input logic [7:0] s);
    logic [71:0] e;
    @(negedge clk);
    sat_req = s_rq; flag_req = f_rq; acc_sel = idx;
    mode_fi = fi; mode_su = su; omc_en = om; acc_in = a; stat_in = s;
    e = model(s_rq, f_rq, idx, fi, su, om, a, s);
    if (!s_rq && !f_rq) e = {last_acc, last_stat};
    @(posedge clk); #1;
    compare(req, e[71:8], e[7:0]);
    last_acc = e[71:8]; last_stat = e[7:0];
    sat_req = 1'b0; flag_req = 1'b0;
  endtask

  function automatic logic [63:0] rnd_val();
    logic [63:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 6)
      0: v = {{16{v[47]}}, v[47:0]};
      1: v = {16'h0, v[47:0]};
      2: v = {{32{v[31]}}, v[31:0]};
      3: v = 64'd0;
      4: v = (64'd1 << 53) + 64'($urandom % 3) - 64'd1;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; sat_req = 0; flag_req = 0; acc_sel = 0;
    mode_fi = 0; mode_su = 0; omc_en = 0; acc_in = '0; stat_in = '0;
    last_acc = '0; last_stat = '0;
    repeat (3) @(posedge clk); #1;
    compare("R1 in reset", 64'd0, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    compare("R1 after release", 64'd0, 8'd0);

    // R3 signed overflow without clamp
    run_op("R3", 1, 0, 2'd1, 0, 1, 0, 64'h0000_8000_0000_0001, 8'h00);
    // R4 signed clamp, both signs
    run_op("R4 neg", 1, 0, 2'd0, 0, 1, 1, 64'h0000_8000_0000_0000, 8'h00);
    run_op("R4 pos", 1, 0, 2'd2, 0, 1, 1, 64'hFFFF_0000_0000_1234, 8'h00);
    // R2 hold with changed inputs
    run_op("R2", 0, 0, 2'd3, 1, 0, 1, 64'h1234_5678_9ABC_DEF0, 8'hFF);
    // R5 unsigned cases
    run_op("R5 big", 1, 0, 2'd3, 0, 0, 1, (64'd1 << 53) + 64'd1, 8'h00);
    run_op("R5 eq", 1, 0, 2'd3, 0, 0, 1, (64'd1 << 53), 8'h00);
    run_op("R5 mask", 1, 0, 2'd1, 0, 0, 0, 64'hABCD_1234_5678_9ABC, 8'h00);
    // R6 fractional clamp
    run_op("R6 neg", 1, 0, 2'd0, 1, 1, 1, 64'h0001_8000_0000_0000, 8'h00);
    run_op("R6 pos", 1, 0, 2'd0, 1, 0, 1, 64'hF000_0000_0000_0001, 8'h00);
    // R7 prior V clamps an in-range value; R8 PAV index
    run_op("R7 R8", 1, 0, 2'd3, 0, 1, 1, 64'h0000_0000_0000_0005, 8'h20);
    // R9 zero and negative
    run_op("R9 zero", 0, 1, 2'd0, 0, 0, 0, 64'd0, 8'h00);
    run_op("R9 neg", 0, 1, 2'd0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    // R10 PAV drives V
    run_op("R10", 0, 1, 2'd2, 0, 1, 0, 64'd7, 8'h04);
    // R11 extension overflow per mode
    run_op("R11 frac", 0, 1, 2'd0, 1, 0, 0, 64'h0000_0100_0000_0000, 8'h00);
    run_op("R11 sint", 0, 1, 2'd0, 0, 1, 0, 64'h0000_0001_0000_0000, 8'h00);
    run_op("R11 uint", 0, 1, 2'd0, 0, 0, 0, 64'hFFFF_FFFF_0000_0000, 8'h00);
    // R12 both strobes chain
    run_op("R12", 1, 1, 2'd1, 0, 1, 1, 64'h0000_8000_0000_0000, 8'h00);
    // R13 sticky bits kept
    run_op("R13", 1, 1, 2'd0, 0, 0, 0, 64'd3, 8'hDA);

    for (int i = 0; i < 600; i++) begin
      logic s_rq, f_rq;
      s_rq = 1'($urandom);
      f_rq = 1'($urandom);
      run_op(s_rq && f_rq ? "R12 rnd" : s_rq ? "R8 rnd" : f_rq ? "R11 rnd" : "R2 rnd",
             s_rq, f_rq, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             rnd_val(), 8'($urandom) & 8'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule